// File: doc/BRIEF.md
# Selectable Line-Code Encoder and Decoder

This block sits between the bit-level datapath of a synchronous serial channel and the physical line. The transmit side takes one NRZ data bit per bit cell and produces the line level for the selected code. The receive side oversamples the incoming line, recovers cell timing with a small phase counter, and delivers each decoded bit with a one-cycle strobe. The run-time mode input selects one of five codes on the same hardware: plain NRZ, NRZI, FM0, FM1 and Manchester.

Both directions are paced by a common sample enable, `tick`, which runs at `OVS` times the bit rate. `OVS` is 16 by default, must be a multiple of four, and must be at least four. A bit cell therefore lasts `OVS` ticks. In local loopback the decoder is fed from the encoder and the line output idles at mark. The mode and loopback inputs are static configuration and change only while reset is held.

Top module: `line_codec`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `tx_line` is 1 and `rx_valid` is 0.
- R2: While `tx_en` is 0, `tx_line` stays at mark (1) whatever `tx_data` and `tick` do. The encoder phase is held so that the first tick after `tx_en` rises starts a new cell.
- R3: With `loopback` at 1, `tx_line` stays at 1. The decoder then takes the encoder's output instead of `rx_line`, so the bits sent are still received.
- R4: Mode encoding is 0 = NRZ, 1 = NRZI, 2 = FM0, 3 = FM1, 4 = Manchester; any other value behaves as NRZ. In NRZ the line equals the data bit for the whole cell.
- R5: In NRZI a 0 inverts the line at the start of the cell and a 1 leaves it unchanged, with no change at mid-cell.
- R6: In FM0 the line inverts at every cell start, and inverts again at mid-cell only for a 0.
- R7: In FM1 the line inverts at every cell start, and inverts again at mid-cell only for a 1.
- R8: In Manchester a 1 is sent as high then low and a 0 as low then high, so the line changes at every mid-cell.
- R9: The data bit is taken on the first tick of each cell. The first-half level appears on `tx_line` one clock after that tick, and the second-half level appears one clock after tick number `OVS/2` of the cell. `tx_line` changes only one clock after a tick, or when the transmitter is disabled.
- R10: The decoder raises no `rx_valid` until it has seen a first line transition. That first transition sets the phase counter to the cell start, or to mid-cell in Manchester mode.
- R11: Once locked, the decoder gives exactly one single-cycle `rx_valid` per cell, one clock after the tick at the three-quarter position. `rx_data` holds the decoded bit, so an encoded stream looped back to the decoder returns the same bits in order.
- R12: Once locked, a transition resynchronises the phase only when it falls on the anchor side of the cell. In Manchester mode that is the middle half of the cell; in the other modes it is the outer half. Transitions elsewhere are ignored.
- R13: `mode` and `loopback` do not change except while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Line code select (0 NRZ, 1 NRZI, 2 FM0, 3 FM1, 4 Manchester) |
| loopback | input | 1 | Local loopback: decoder fed from encoder, line held at mark |
| tick | input | 1 | Sample enable at OVS times the bit rate, one clock wide |
| tx_en | input | 1 | Transmitter enable |
| tx_data | input | 1 | Data bit, taken on the first tick of each cell |
| tx_line | output | 1 | Encoded line level (registered) |
| rx_line | input | 1 | Incoming line level |
| rx_data | output | 1 | Decoded bit, valid with rx_valid |
| rx_valid | output | 1 | One-cycle strobe per decoded cell |

## Verification
Four properties are checked on every cycle. The line idles at mark while the transmitter is off or looped back. The line moves only in the clock after a tick or a disable. The receive strobe is always a single cycle that follows a tick. The configuration stays still outside reset. The per-mode waveforms can only be shown by the bench scenarios: it checks each half-cell of each code against its own level model. The same holds for acquiring lock on the first edge, rejecting mid-cell edges in the FM codes and boundary edges in Manchester, and carrying bits through the internal loopback path. All of these are checked by comparing the decoded stream with the bits sent.

// File: rtl/line_codec_pkg.sv
package line_codec_pkg;

    typedef enum logic [2:0] {
        LC_NRZ   = 3'd0,
        LC_NRZI  = 3'd1,
        LC_FM0   = 3'd2,
        LC_FM1   = 3'd3,
        LC_MANCH = 3'd4
    } lc_mode_e;

    // Receive-side single-bit state carried as one record
    typedef struct packed {
        logic locked;   // first transition seen
        logic last;     // line level at previous tick
        logic q1;       // sample at the quarter-cell position
        logic prev;     // level of previous cell (NRZI reference)
    } lc_rx_state_t;

    function automatic lc_mode_e to_mode(logic [2:0] raw);
        case (raw)
            3'd1:    return LC_NRZI;
            3'd2:    return LC_FM0;
            3'd3:    return LC_FM1;
            3'd4:    return LC_MANCH;
            default: return LC_NRZ;
        endcase
    endfunction

    // Level driven at the start of a cell
    function automatic logic cell_start_level(lc_mode_e m, logic b, logic lvl);
        case (m)
            LC_NRZI:        return b ? lvl : ~lvl;
            LC_FM0, LC_FM1: return ~lvl;
            default:        return b;          // NRZ and Manchester
        endcase
    endfunction

    // Level driven at mid-cell
    function automatic logic cell_mid_level(lc_mode_e m, logic b, logic lvl);
        case (m)
            LC_FM0:   return b ? lvl : ~lvl;
            LC_FM1:   return b ? ~lvl : lvl;
            LC_MANCH: return ~lvl;
            default:  return lvl;
        endcase
    endfunction

    // Recover a bit from the quarter and three-quarter samples
    function automatic logic decode_cell(lc_mode_e m, logic q1, logic q3, logic prev);
        case (m)
            LC_NRZI:  return q3 == prev;
            LC_FM0:   return q1 == q3;
            LC_FM1:   return q1 != q3;
            LC_MANCH: return ~q3;
            default:  return q3;
        endcase
    endfunction

    function automatic logic anchors_mid(lc_mode_e m);
        return m == LC_MANCH;
    endfunction

endpackage

// File: rtl/lc_encoder.sv
module lc_encoder
    import line_codec_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  lc_mode_e mode,
    input  logic     tick,
    input  logic     tx_en,
    input  logic     tx_data,
    output logic     lvl_next,
    output logic     lvl
);
    localparam int PW = $clog2(OVS);
    localparam logic [PW-1:0] MID  = PW'(OVS / 2);
    localparam logic [PW-1:0] LAST = PW'(OVS - 1);

    logic [PW-1:0] tph;
    logic          cur_bit;

    always_comb begin
        lvl_next = lvl;
        if (!tx_en) begin
            lvl_next = 1'b1;
        end else if (tick) begin
            if (tph == '0)
                lvl_next = cell_start_level(mode, tx_data, lvl);
            else if (tph == MID)
                lvl_next = cell_mid_level(mode, cur_bit, lvl);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tph     <= '0;
            lvl     <= 1'b1;
            cur_bit <= 1'b0;
        end else begin
            lvl <= lvl_next;
            if (!tx_en) begin
                tph <= '0;
            end else if (tick) begin
                tph <= (tph == LAST) ? '0 : tph + 1'b1;
                if (tph == '0)
                    cur_bit <= tx_data;
            end
        end
    end

endmodule

// File: rtl/lc_decoder.sv
module lc_decoder
    import line_codec_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  lc_mode_e mode,
    input  logic     tick,
    input  logic     line,
    output logic     rx_data,
    output logic     rx_valid
);
    localparam int PW = $clog2(OVS);
    localparam logic [PW-1:0] POS_Q1  = PW'(OVS / 4);
    localparam logic [PW-1:0] POS_MID = PW'(OVS / 2);
    localparam logic [PW-1:0] POS_Q3  = PW'(3 * OVS / 4);
    localparam logic [PW-1:0] LAST    = PW'(OVS - 1);

    lc_rx_state_t  st;
    logic [PW-1:0] ph;
    logic [PW-1:0] eff;
    logic          edge_seen;
    logic          in_mid_half;
    logic          accept;

    always_comb begin
        edge_seen   = tick && (line != st.last);
        in_mid_half = (ph > POS_Q1) && (ph < POS_Q3);
        if (!st.locked)
            accept = edge_seen;
        else if (anchors_mid(mode))
            accept = edge_seen && in_mid_half;
        else
            accept = edge_seen && !in_mid_half;
        if (accept)
            eff = anchors_mid(mode) ? POS_MID : '0;
        else
            eff = ph;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '{locked: 1'b0, last: 1'b1, q1: 1'b1, prev: 1'b1};
            ph       <= '0;
            rx_data  <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (tick) begin
                st.last <= line;
                ph      <= (eff == LAST) ? '0 : eff + 1'b1;
                if (accept)
                    st.locked <= 1'b1;
                if (eff == POS_Q1)
                    st.q1 <= line;
                if (st.locked && eff == POS_Q3) begin
                    rx_data  <= decode_cell(mode, st.q1, line, st.prev);
                    rx_valid <= 1'b1;
                    st.prev  <= line;
                end
            end
        end
    end

endmodule

// File: rtl/line_codec.sv
module line_codec
    import line_codec_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode,
    input  logic       loopback,
    input  logic       tick,
    input  logic       tx_en,
    input  logic       tx_data,
    output logic       tx_line,
    input  logic       rx_line,
    output logic       rx_data,
    output logic       rx_valid
);
    lc_mode_e sel;
    logic     enc_next;
    logic     enc_lvl;
    logic     dec_in;

    assign sel    = to_mode(mode);
    assign dec_in = loopback ? enc_lvl : rx_line;

    lc_encoder #(.OVS(OVS)) u_enc (
        .clk      (clk),
        .rst      (rst),
        .mode     (sel),
        .tick     (tick),
        .tx_en    (tx_en),
        .tx_data  (tx_data),
        .lvl_next (enc_next),
        .lvl      (enc_lvl)
    );

    lc_decoder #(.OVS(OVS)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .mode     (sel),
        .tick     (tick),
        .line     (dec_in),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    always_ff @(posedge clk) begin
        if (rst)
            tx_line <= 1'b1;
        else
            tx_line <= (tx_en && !loopback) ? enc_next : 1'b1;
    end

endmodule

// File: rtl/line_codec_chk.sv
module line_codec_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode,
    input logic       loopback,
    input logic       tick,
    input logic       tx_en,
    input logic       tx_line,
    input logic       rx_valid
);
    // R2 R3
    idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_en || loopback) |=> tx_line);

    // R9
    line_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tx_line) |-> ($past(tick) || !$past(tx_en)));

    // R11
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R11
    strobe_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(tick));

    // R13
    cfg_static_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(mode) && $stable(loopback));

endmodule

bind line_codec line_codec_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .loopback (loopback),
    .tick     (tick),
    .tx_en    (tx_en),
    .tx_line  (tx_line),
    .rx_valid (rx_valid)
);

// File: tb/line_codec_tb.sv
module line_codec_tb;
    localparam int OVS = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode = 3'd0;
    logic       loopback = 1'b0;
    logic       tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_data = 1'b0;
    logic       tx_line;
    logic       rx_data;
    logic       rx_valid;

    int checks = 0;
    int fails  = 0;
    int stray  = 0;
    bit mon_en = 1'b0;
    bit expq[$];

    always #5 clk = ~clk;

    line_codec #(.OVS(OVS)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .loopback (loopback),
        .tick     (tick),
        .tx_en    (tx_en),
        .tx_data  (tx_data),
        .tx_line  (tx_line),
        .rx_line  (tx_line),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Monitor: pops expected bits as decoded bits appear
    always @(negedge clk) begin
        if (rx_valid) begin
            if (!mon_en) begin
                stray++;
            end else if (expq.size() == 0) begin
                check(1'b0, "R11 unexpected strobe", 1, 0);
            end else begin
                automatic bit e = expq.pop_front();
                check(rx_data === e, "R11 decoded bit", int'(rx_data), int'(e));
            end
        end
    end

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic apply_reset(input logic [2:0] m, input logic lb);
        @(negedge clk);
        rst = 1'b1; tick = 1'b0; tx_en = 1'b0; mon_en = 1'b0;
        mode = m; loopback = lb;
        repeat (3) @(negedge clk);
        check(tx_line === 1'b1 && rx_valid === 1'b0, "R1 reset state", int'(tx_line), 1);
        rst = 1'b0;
        @(negedge clk);
        check(tx_line === 1'b1 && rx_valid === 1'b0, "R1 after release", int'(tx_line), 1);
    endtask

    // Driver: expected levels from the code rules, bits pushed to the scoreboard
    task automatic send(input logic [2:0] m, input logic lb, input logic [31:0] seq, input int n);
        logic lvl = 1'b1;
        string tag;
        case (m)
            3'd1: tag = "R5 NRZI";
            3'd2: tag = "R6 FM0";
            3'd3: tag = "R7 FM1";
            3'd4: tag = "R8 Manchester";
            default: tag = "R4 NRZ";
        endcase
        if (lb) tag = {"R3 loopback ", tag};
        apply_reset(m, lb);
        // R2 R10: disabled transmitter, toggling data, no strobe
        stray = 0;
        for (int i = 0; i < 20; i++) begin
            tx_data = i[0];
            do_tick();
            if (i % 5 == 4)
                check(tx_line === 1'b1, "R2 idle mark", int'(tx_line), 1);
        end
        check(stray == 0, "R10 no strobe before lock", stray, 0);
        mon_en = 1'b1;
        tx_en = 1'b1;
        for (int k = 0; k < n; k++) begin
            automatic logic b = seq[k];
            automatic logic h1, h2;
            case (m)
                3'd1: begin h1 = b ? lvl : ~lvl; h2 = h1; end
                3'd2: begin h1 = ~lvl; h2 = b ? h1 : ~h1; end
                3'd3: begin h1 = ~lvl; h2 = b ? ~h1 : h1; end
                3'd4: begin h1 = b; h2 = ~b; end
                default: begin h1 = b; h2 = b; end
            endcase
            lvl = h2;
            if (lb) begin h1 = 1'b1; h2 = 1'b1; end
            tx_data = b;
            expq.push_back(b);
            for (int t = 0; t < OVS; t++) begin
                do_tick();
                // R9: first half after tick 0, still first half before mid tick
                if (t == 0 || t == OVS / 2 - 1)
                    check(tx_line === h1, {tag, " first half"}, int'(tx_line), int'(h1));
                if (t == OVS / 2 || t == OVS - 1)
                    check(tx_line === h2, {tag, " second half"}, int'(tx_line), int'(h2));
            end
        end
        check(expq.size() == 0, "R11 all bits decoded", expq.size(), 0);
        mon_en = 1'b0;
        expq.delete();
        tx_en = 1'b0;
        do_tick();
        check(tx_line === 1'b1, "R2 mark after disable", int'(tx_line), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=0 expected=1");
        fails++;
        report();
        $finish;
    end

    initial begin
        // Preambles give an anchor-type first transition (R10, R12)
        send(3'd0, 1'b0, {14'd0, 16'hB38D, 2'b10}, 18);
        send(3'd1, 1'b0, {14'd0, 16'h5A3C, 2'b00}, 18);
        send(3'd2, 1'b0, {14'd0, 16'hC6E1, 2'b11}, 18);
        send(3'd3, 1'b0, {14'd0, 16'h93B4, 2'b00}, 18);
        send(3'd4, 1'b0, {12'd0, 16'h2F76, 4'b0101}, 20);
        send(3'd6, 1'b0, {14'd0, 16'h1DE2, 2'b10}, 18);   // R4 undefined code as NRZ
        send(3'd4, 1'b1, {12'd0, 16'hA5C3, 4'b0101}, 20);
        send(3'd3, 1'b1, {14'd0, 16'h7E18, 2'b00}, 18);
        report();
        $finish;
    end

endmodule